// File: doc/BRIEF.md
# I2C Interrupt Vector and Status Unit

This unit gathers the event pulses produced by an I2C bus engine and turns them into latched flags that a host processor can inspect, mask and acknowledge over a simple word-addressed register port. Seven events are tracked: arbitration lost, NACK received, access ready, receive data ready, transmit data ready, stop detected and addressed as slave. Each pulse sets a sticky flag. The flag stays set until software clears it, whether or not its interrupt is enabled.

Software normally works from the vector register. A read returns a small code that names the highest-priority flag that is both pending and enabled. The same read acknowledges that flag, so an interrupt handler can keep reading until the code is zero. Flags can also be cleared through the status register by writing ones. The status register also shows two live engine signals, receive-shift-register full and bus busy. A single registered interrupt line tells the processor that at least one enabled flag is pending.

Top module: `i2c_evt_irq_unit`

## Requirements
- R1: After reset all flags and mask bits are 0, the interrupt line is low, and reads of the mask, status and vector registers return 0 while both live inputs are low.
- R2: A one-cycle pulse on event input bit i sets flag i whatever the mask holds. Flag i reads back at status bit i. Bit order: 0 arbitration lost, 1 NACK, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop detected, 6 addressed as slave.
- R3: The mask register at byte offset 0x04 holds one enable per event, in the bit order of R2. It reads back in bits 6..0, and bits 15..7 always read 0.
- R4: A read of the vector register at offset 0x28 returns i+1 for the lowest-numbered flag i that is both set and enabled, so arbitration lost (code 1) has the highest priority. It returns 0 when no enabled flag is pending. Pending flags that are masked never appear.
- R5: A vector read that returns a nonzero code clears exactly the reported flag. Repeated reads therefore step through the enabled pending flags in priority order and end with 0.
- R6: A write to the status register at offset 0x08 clears each flag whose data bit (6..0) is 1 and leaves each flag whose data bit is 0 unchanged.
- R7: Status bit 11 shows the receive-shift-full input and bit 12 shows the bus-busy input as live values at the time of the read. Writes to these bits have no effect.
- R8: If an event pulse arrives in the same cycle that a status write or a vector read clears the same flag, the flag stays set.
- R9: The interrupt line goes high one clock after any flag is both set and enabled. It goes low one clock after no such flag remains, including when only the mask changes.
- R10: Writes to the vector register or to unmapped offsets change no state. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ev_pulse_i | input | 7 | Event pulses from the bus engine, bit order as in R2 |
| rsfull_i | input | 1 | Live receive-shift-register-full indication |
| busy_i | input | 1 | Live bus-busy indication |
| bus_addr_i | input | 8 | Register byte offset |
| bus_wr_i | input | 1 | Write strobe, one cycle |
| bus_rd_i | input | 1 | Read strobe, one cycle |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, valid from the clock after the read strobe and held until the next read |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A wrong flag, mask or priority state is visible at the ports within one read. A status read shows the raw flags. A vector read shows the result of the priority and mask logic, and the interrupt line shows the same result one clock after every change. Clearing faults, such as a read clearing the wrong flag, or a set losing to a clear, show up on the next vector or status read as a code or bit that should or should not be there. The bench reads after every stimulus step, so a corrupted flag is reported within one or two register accesses of the event that caused it.

// File: rtl/ievu_pkg.sv
package ievu_pkg;

   // Register selected by the current bus address
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_MASK = 2'd1,
      SEL_STAT = 2'd2,
      SEL_VEC  = 2'd3
   } reg_sel_e;

   // Number of bits needed to hold codes 0..n
   function automatic int unsigned code_width(input int unsigned n);
      int unsigned w;
      w = 1;
      while ((2 ** w) <= n) w++;
      return w;
   endfunction

endpackage

// File: rtl/ievu_flag_bank.sv
module ievu_flag_bank #(
   parameter int unsigned EVT_N = 7
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [EVT_N-1:0] set_i,
   input  logic [EVT_N-1:0] clr_i,
   output logic [EVT_N-1:0] flag_o
);

   logic [EVT_N-1:0] flag_q;

   if (EVT_N < 1) begin : g_chk_n
      $error("ievu_flag_bank: EVT_N must be at least 1");
   end

   // One sticky flop per event; a new event beats a clear in the same cycle
   for (genvar g = 0; g < EVT_N; g++) begin : g_flag
      always_ff @(posedge clk_i) begin
         if (!rst_ni)         flag_q[g] <= 1'b0;
         else if (set_i[g])   flag_q[g] <= 1'b1;
         else if (clr_i[g])   flag_q[g] <= 1'b0;
      end
   end

   assign flag_o = flag_q;

   p_set_wins_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i != '0) |=> ((flag_q & $past(set_i)) == $past(set_i)));

   p_clear_takes_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((clr_i & ~set_i) != '0) |=> ((flag_q & $past(clr_i & ~set_i)) == '0));

   p_hold_idle_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((set_i == '0) && (clr_i == '0)) |=> $stable(flag_q));

endmodule

// File: rtl/ievu_prio_enc.sv
module ievu_prio_enc #(
   parameter int unsigned EVT_N     = 7,
   parameter int unsigned VEC_W     = 3,
   parameter bit          LOW_FIRST = 1'b1
) (
   input  logic [EVT_N-1:0] req_i,
   output logic [VEC_W-1:0] code_o,
   output logic [EVT_N-1:0] grant_o
);

   if (EVT_N > (2 ** VEC_W) - 1) begin : g_chk_w
      $error("ievu_prio_enc: VEC_W too narrow for EVT_N codes");
   end

   // The last match in loop order wins, so the loop direction sets priority
   if (LOW_FIRST) begin : g_low
      always_comb begin
         code_o  = '0;
         grant_o = '0;
         for (int i = EVT_N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
               code_o     = VEC_W'(i + 1);
               grant_o    = '0;
               grant_o[i] = 1'b1;
            end
         end
      end
   end else begin : g_high
      always_comb begin
         code_o  = '0;
         grant_o = '0;
         for (int i = 0; i < EVT_N; i++) begin
            if (req_i[i]) begin
               code_o     = VEC_W'(i + 1);
               grant_o    = '0;
               grant_o[i] = 1'b1;
            end
         end
      end
   end

   always_comb begin
      a_grant_onehot_r4 : assert ($onehot0(grant_o));
      a_zero_idle_r4 : assert ((req_i != '0) || (code_o == '0));
   end

endmodule

// File: rtl/ievu_regif.sv
module ievu_regif
   import ievu_pkg::*;
#(
   parameter int unsigned          EVT_N    = 7,
   parameter int unsigned          DATA_W   = 16,
   parameter int unsigned          ADDR_W   = 8,
   parameter int unsigned          VEC_W    = 3,
   parameter logic [ADDR_W-1:0]    MASK_OFS = 'h04,
   parameter logic [ADDR_W-1:0]    STAT_OFS = 'h08,
   parameter logic [ADDR_W-1:0]    VEC_OFS  = 'h28,
   parameter int unsigned          RSF_BIT  = 11,
   parameter int unsigned          BB_BIT   = 12
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [EVT_N-1:0]  flag_i,
   input  logic [EVT_N-1:0]  pend_i,
   input  logic [VEC_W-1:0]  code_i,
   input  logic              rsfull_i,
   input  logic              busy_i,
   output logic [EVT_N-1:0]  mask_o,
   output logic [EVT_N-1:0]  w1c_o,
   output logic              vec_rd_o,
   output logic [DATA_W-1:0] rdata_o
);

   reg_sel_e          sel;
   logic [EVT_N-1:0]  mask_q;
   logic [DATA_W-1:0] rd_val;
   logic [DATA_W-1:0] rdata_q;
   logic              unused_wdata;

   if ((RSF_BIT >= DATA_W) || (BB_BIT >= DATA_W) || (RSF_BIT == BB_BIT)) begin : g_chk_live
      $error("ievu_regif: live status bits must be distinct and inside DATA_W");
   end
   if ((EVT_N > RSF_BIT) || (EVT_N > BB_BIT)) begin : g_chk_ovl
      $error("ievu_regif: event flags overlap live status bits");
   end
   if (VEC_W > DATA_W) begin : g_chk_vec
      $error("ievu_regif: vector code wider than data bus");
   end

   assign unused_wdata = ^wdata_i[DATA_W-1:EVT_N];

   always_comb begin
      if (addr_i == MASK_OFS)      sel = SEL_MASK;
      else if (addr_i == STAT_OFS) sel = SEL_STAT;
      else if (addr_i == VEC_OFS)  sel = SEL_VEC;
      else                         sel = SEL_NONE;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)                        mask_q <= '0;
      else if (wr_i && (sel == SEL_MASK)) mask_q <= wdata_i[EVT_N-1:0];
   end

   assign w1c_o    = (wr_i && (sel == SEL_STAT)) ? wdata_i[EVT_N-1:0] : '0;
   assign vec_rd_o = rd_i && (sel == SEL_VEC);
   assign mask_o   = mask_q;

   always_comb begin
      rd_val = '0;
      case (sel)
         SEL_MASK: rd_val[EVT_N-1:0] = mask_q;
         SEL_STAT: begin
            rd_val[EVT_N-1:0] = flag_i;
            rd_val[RSF_BIT]   = rsfull_i;
            rd_val[BB_BIT]    = busy_i;
         end
         SEL_VEC:  rd_val[VEC_W-1:0] = code_i;
         default:  rd_val = '0;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)   rdata_q <= '0;
      else if (rd_i) rdata_q <= rd_val;
   end

   assign rdata_o = rdata_q;

   p_busy_live_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && (addr_i == STAT_OFS)) |=> (rdata_q[BB_BIT] == $past(busy_i)));

   p_vec_zero_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && (addr_i == VEC_OFS) && (pend_i == '0)) |=> (rdata_q == '0));

   p_mask_hold_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_i && (addr_i == MASK_OFS)) |=> $stable(mask_q));

   p_rdata_hold_r10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_i |=> $stable(rdata_q));

endmodule

// File: rtl/i2c_evt_irq_unit.sv
module i2c_evt_irq_unit #(
   parameter int unsigned       EVT_N     = 7,
   parameter int unsigned       DATA_W    = 16,
   parameter int unsigned       ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] MASK_OFS  = 'h04,
   parameter logic [ADDR_W-1:0] STAT_OFS  = 'h08,
   parameter logic [ADDR_W-1:0] VEC_OFS   = 'h28,
   parameter int unsigned       RSF_BIT   = 11,
   parameter int unsigned       BB_BIT    = 12,
   parameter bit                LOW_FIRST = 1'b1,
   parameter bit                IRQ_REG   = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [EVT_N-1:0]  ev_pulse_i,
   input  logic              rsfull_i,
   input  logic              busy_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_wr_i,
   input  logic              bus_rd_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              irq_o
);

   localparam int unsigned VEC_W = ievu_pkg::code_width(EVT_N);

   logic [EVT_N-1:0] flags;
   logic [EVT_N-1:0] mask;
   logic [EVT_N-1:0] pend;
   logic [EVT_N-1:0] grant;
   logic [EVT_N-1:0] w1c;
   logic [EVT_N-1:0] clr;
   logic [VEC_W-1:0] code;
   logic             vec_rd;

   if ((MASK_OFS == STAT_OFS) || (MASK_OFS == VEC_OFS) || (STAT_OFS == VEC_OFS)) begin : g_chk_ofs
      $error("i2c_evt_irq_unit: register offsets must differ");
   end

   assign pend = flags & mask;
   assign clr  = w1c | (grant & {EVT_N{vec_rd}});

   ievu_flag_bank #(.EVT_N(EVT_N)) u_flags (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (ev_pulse_i),
      .clr_i  (clr),
      .flag_o (flags)
   );

   ievu_prio_enc #(
      .EVT_N     (EVT_N),
      .VEC_W     (VEC_W),
      .LOW_FIRST (LOW_FIRST)
   ) u_prio (
      .req_i   (pend),
      .code_o  (code),
      .grant_o (grant)
   );

   ievu_regif #(
      .EVT_N    (EVT_N),
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .VEC_W    (VEC_W),
      .MASK_OFS (MASK_OFS),
      .STAT_OFS (STAT_OFS),
      .VEC_OFS  (VEC_OFS),
      .RSF_BIT  (RSF_BIT),
      .BB_BIT   (BB_BIT)
   ) u_regs (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .addr_i   (bus_addr_i),
      .wr_i     (bus_wr_i),
      .rd_i     (bus_rd_i),
      .wdata_i  (bus_wdata_i),
      .flag_i   (flags),
      .pend_i   (pend),
      .code_i   (code),
      .rsfull_i (rsfull_i),
      .busy_i   (busy_i),
      .mask_o   (mask),
      .w1c_o    (w1c),
      .vec_rd_o (vec_rd),
      .rdata_o  (bus_rdata_o)
   );

   if (IRQ_REG) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk_i) begin
         if (!rst_ni) irq_q <= 1'b0;
         else         irq_q <= |pend;
      end
      assign irq_o = irq_q;

      p_irq_rise_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         $rose(irq_o) |-> $past(|(flags & mask)));
      p_irq_fall_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         $fell(irq_o) |-> $past((flags & mask) == '0));
   end else begin : g_irq_comb
      assign irq_o = |pend;
   end

   p_vec_clear_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vec_rd && (grant != '0) && ((grant & ev_pulse_i) == '0))
         |=> ((flags & $past(grant)) == '0));

   p_vec_only_one_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vec_rd && (w1c == '0)) |=> ($countones($past(flags) & ~flags) <= 1));

endmodule

// File: tb/test_i2c_evt_irq_unit.sv
module test_i2c_evt_irq_unit;

   localparam logic [7:0] A_MASK = 8'h04;
   localparam logic [7:0] A_STAT = 8'h08;
   localparam logic [7:0] A_VEC  = 8'h28;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  ev = '0;
   logic        rsfull = 1'b0;
   logic        busy = 1'b0;
   logic [7:0]  addr = '0;
   logic        wr = 1'b0;
   logic        rd = 1'b0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        irq;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   i2c_evt_irq_unit i_i2c_evt_irq_unit (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .ev_pulse_i  (ev),
      .rsfull_i    (rsfull),
      .busy_i      (busy),
      .bus_addr_i  (addr),
      .bus_wr_i    (wr),
      .bus_rd_i    (rd),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .irq_o       (irq)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [15:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [15:0] d);
      @(negedge clk);
      addr = a; rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
      d = rdata;
   endtask

   task automatic pulse(input logic [6:0] e);
      @(negedge clk);
      ev = e;
      @(negedge clk);
      ev = '0;
   endtask

   task automatic t_reset;
      logic [15:0] d;
      chk("R1 irq after reset", 16'(irq), 16'h0);
      bus_rd(A_MASK, d); chk("R1 mask reset", d, 16'h0000);
      bus_rd(A_STAT, d); chk("R1 status reset", d, 16'h0000);
      bus_rd(A_VEC, d);  chk("R1 vector reset", d, 16'h0000);
   endtask

   task automatic t_latch;
      logic [15:0] d;
      pulse(7'b0100101);
      bus_rd(A_STAT, d); chk("R2 flags latch while masked", d, 16'h0025);
      bus_rd(A_VEC, d);  chk("R4 masked flags give code 0", d, 16'h0000);
      chk("R9 no irq while masked", 16'(irq), 16'h0);
      bus_wr(A_STAT, 16'h007F);
      bus_rd(A_STAT, d); chk("R6 clear all", d, 16'h0000);
   endtask

   task automatic t_mask;
      logic [15:0] d;
      bus_wr(A_MASK, 16'hFFFF);
      bus_rd(A_MASK, d); chk("R3 upper mask bits read 0", d, 16'h007F);
      bus_wr(A_MASK, 16'h0055);
      bus_rd(A_MASK, d); chk("R3 mask readback", d, 16'h0055);
   endtask

   task automatic t_vector;
      logic [15:0] d;
      bus_wr(A_MASK, 16'h007F);
      pulse(7'h7F);
      @(negedge clk);
      chk("R9 irq high with enabled flag", 16'(irq), 16'h1);
      for (int k = 1; k <= 7; k++) begin
         bus_rd(A_VEC, d); chk($sformatf("R5 vector walk step %0d", k), d, 16'(k));
      end
      bus_rd(A_VEC, d); chk("R4 vector drained", d, 16'h0000);
      bus_rd(A_STAT, d); chk("R5 all flags acknowledged", d, 16'h0000);
      chk("R9 irq low when drained", 16'(irq), 16'h0);
      bus_wr(A_MASK, 16'h007E);
      pulse(7'b0000011);
      bus_rd(A_VEC, d); chk("R4 masked AL skipped", d, 16'h0002);
      bus_rd(A_VEC, d); chk("R4 only masked left", d, 16'h0000);
      bus_rd(A_STAT, d); chk("R5 masked flag untouched", d, 16'h0001);
      bus_wr(A_STAT, 16'h0001);
   endtask

   task automatic t_w1c;
      logic [15:0] d;
      pulse(7'h7F);
      bus_wr(A_STAT, 16'h0012);
      bus_rd(A_STAT, d); chk("R6 w1c selected bits", d, 16'h006D);
      bus_wr(A_STAT, 16'h0000);
      bus_rd(A_STAT, d); chk("R6 zero write keeps flags", d, 16'h006D);
      bus_wr(A_STAT, 16'h007F);
      bus_rd(A_STAT, d); chk("R6 clear rest", d, 16'h0000);
   endtask

   task automatic t_live;
      logic [15:0] d;
      @(negedge clk); rsfull = 1'b1; busy = 1'b1;
      bus_rd(A_STAT, d); chk("R7 live bits", d, 16'h1800);
      bus_wr(A_STAT, 16'hFFFF);
      bus_rd(A_STAT, d); chk("R7 live bits ignore write", d, 16'h1800);
      @(negedge clk); busy = 1'b0;
      bus_rd(A_STAT, d); chk("R7 busy follows input", d, 16'h0800);
      @(negedge clk); rsfull = 1'b0;
   endtask

   task automatic t_set_wins;
      logic [15:0] d;
      @(negedge clk);
      addr = A_STAT; wdata = 16'h0002; wr = 1'b1; ev = 7'b0000010;
      @(negedge clk);
      wr = 1'b0; ev = '0;
      bus_rd(A_STAT, d); chk("R8 set beats w1c", d, 16'h0002);
      @(negedge clk);
      addr = A_VEC; rd = 1'b1; ev = 7'b0000010;
      @(negedge clk);
      rd = 1'b0; ev = '0;
      chk("R8 vector read code", rdata, 16'h0002);
      bus_rd(A_VEC, d); chk("R8 set beats vector clear", d, 16'h0002);
      bus_rd(A_VEC, d); chk("R5 drained after second read", d, 16'h0000);
   endtask

   task automatic t_irq;
      bus_wr(A_MASK, 16'h0000);
      pulse(7'b0010000);
      @(negedge clk);
      chk("R9 irq low, masked", 16'(irq), 16'h0);
      bus_wr(A_MASK, 16'h0010);
      chk("R9 irq lags mask by a clock", 16'(irq), 16'h0);
      @(negedge clk);
      chk("R9 irq rises after unmask", 16'(irq), 16'h1);
      bus_wr(A_STAT, 16'h0010);
      chk("R9 irq still high the clear cycle", 16'(irq), 16'h1);
      @(negedge clk);
      chk("R9 irq falls after clear", 16'(irq), 16'h0);
   endtask

   task automatic t_ignore;
      logic [15:0] d;
      bus_wr(A_MASK, 16'h0033);
      pulse(7'b0001000);
      bus_wr(A_VEC, 16'hFFFF);
      bus_wr(8'h10, 16'hFFFF);
      bus_rd(A_STAT, d); chk("R10 flags unchanged by stray writes", d, 16'h0008);
      bus_rd(A_MASK, d); chk("R10 mask unchanged by stray writes", d, 16'h0033);
      bus_rd(8'h10, d);  chk("R10 unmapped read zero", d, 16'h0000);
      bus_wr(A_STAT, 16'h0008);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_latch();
      t_mask();
      t_vector();
      t_w1c();
      t_live();
      t_set_wins();
      t_irq();
      t_ignore();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule